// File: doc/BRIEF.md
# Supply-Loss Write Guard for Battery-Backed Memory

This block supervises a static memory array that keeps its contents on a backup battery. Three comparator flags come from outside the block, and each one reports that the external supply sits above a threshold. The high flag is at about 3.0 V, the middle flag at about 2.8 V and the low flag at about 2.5 V. The block synchronizes the flags and tracks the supply condition in a four-state machine. From that state it decides whether the host may reach the array, and whether the array is fed from the external rail or from the battery.

The block also decodes the host's active-low chip-enable, write-enable and output-enable strobes. It produces a data-output drive enable and an array write strobe. Both are gated by the supply state. A write that is cut off by a falling supply stays blocked until the host closes the strobe window and opens a new one.

Top module: `pwr_guard_ctrl`

## Requirements
- R1: While reset is held and right after it, the state is BATTERY (code 2'b10), `batt_sel` is 1, and `host_ok`, `dq_oe` and `array_we` are 0 whatever the strobes do.
- R2: Each supply flag passes through two flip-flops before the state register. A flag change applied before a rising edge affects the state only after the third rising edge.
- R3: The state codes are NORMAL=2'b00, PROTECT=2'b01, BATTERY=2'b10 and RECOVER=2'b11. NORMAL is entered from PROTECT or RECOVER only when the synchronized high and middle flags are both set. `host_ok` is 1 only in NORMAL.
- R4: In NORMAL with the low flag set, clearing the high or middle flag moves the state to PROTECT. Outside NORMAL every strobe is ignored: `dq_oe` and `array_we` stay 0.
- R5: A cleared synchronized low flag moves any state to BATTERY. This rule takes priority over all other transitions. `batt_sel` is 1 only in BATTERY.
- R6: BATTERY moves to RECOVER when the low flag is set, and never goes straight to NORMAL. RECOVER keeps host access blocked until R3 allows NORMAL.
- R7: `dq_oe` is 1 exactly when the state is NORMAL, `we_n` is 1 and both `ce_n` and `oe_n` are 0.
- R8: The write window is the time when `ce_n` and `we_n` are both low. It opens at the later of the two falling edges and closes at the earlier rising edge. `array_we` follows that window in NORMAL.
- R9: While `array_we` is 1, `dq_oe` is 0 even if `oe_n` is low.
- R10: If the write window is open at a rising edge while the state is not NORMAL, `array_we` stays 0 until a rising edge samples the window closed. It stays 0 even after the state returns to NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_hi_raw | input | 1 | Asynchronous flag: supply above the full-operation threshold |
| sup_mid_raw | input | 1 | Asynchronous flag: supply above the write-block threshold |
| sup_lo_raw | input | 1 | Asynchronous flag: supply above the battery-switch threshold |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| host_ok | output | 1 | Host accesses are allowed |
| dq_oe | output | 1 | Drive the data outputs (0 means high impedance) |
| array_we | output | 1 | Write strobe to the memory array |
| batt_sel | output | 1 | Array supply select, 1 selects the battery |
| pwr_state | output | 2 | Current supply state code |

## Verification
A wrong state shows up within one cycle on `pwr_state`, and on `host_ok` or `batt_sel`. A skipped or extra synchronizer stage shifts every transition by one edge, which the latency checks after reset and after each flag change detect. A lost or stuck write-block flag shows up on `array_we` as a spurious strobe, or a missing one, in the first cycle of a held or a fresh write window after the state returns to NORMAL. Random supply ramps interleaved with random strobe patterns exercise every transition against a reference state model held in the bench.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL  = 2'b00,
        ST_PROTECT = 2'b01,
        ST_BATTERY = 2'b10,
        ST_RECOVER = 2'b11
    } pwr_state_e;

    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } sup_flags_t;

    localparam int unsigned NUM_FLAGS = $bits(sup_flags_t);
endpackage

// File: rtl/pgc_sync.sv
module pgc_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = din;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pgc_fsm.sv
module pgc_fsm
    import pgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sup_flags_t flags,
    output pwr_state_e state
);
    typedef struct packed {
        pwr_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      full_ok;

    always_comb begin
        full_ok = flags.hi && flags.mid;
        r_d     = r_q;
        if (!flags.lo) begin
            r_d.st = ST_BATTERY;
        end else begin
            unique case (r_q.st)
                ST_NORMAL:  if (!full_ok) r_d.st = ST_PROTECT;
                ST_PROTECT: if (full_ok)  r_d.st = ST_NORMAL;
                ST_BATTERY: r_d.st = ST_RECOVER;
                ST_RECOVER: if (full_ok)  r_d.st = ST_NORMAL;
                default:    r_d.st = ST_BATTERY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_BATTERY};
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/pgc_strobe.sv
module pgc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic dq_oe,
    output logic array_we
);
    typedef struct packed {
        logic blocked;
    } strb_regs_t;

    strb_regs_t r_d, r_q;
    logic       wr_win;
    logic       rd_win;

    always_comb begin
        wr_win    = !ce_n && !we_n;
        rd_win    = !ce_n && !oe_n && we_n;
        r_d       = r_q;
        r_d.blocked = wr_win && (r_q.blocked || !access);
        array_we  = access && wr_win && !r_q.blocked;
        dq_oe     = access && rd_win;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{blocked: 1'b0};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pwr_guard_ctrl.sv
module pwr_guard_ctrl
    import pgc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_hi_raw,
    input  logic       sup_mid_raw,
    input  logic       sup_lo_raw,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    output logic       host_ok,
    output logic       dq_oe,
    output logic       array_we,
    output logic       batt_sel,
    output logic [1:0] pwr_state
);
    sup_flags_t raw_flags;
    sup_flags_t sync_flags;
    pwr_state_e state;

    assign raw_flags = '{hi: sup_hi_raw, mid: sup_mid_raw, lo: sup_lo_raw};

    pgc_sync #(
        .WIDTH (NUM_FLAGS),
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_flags),
        .dout (sync_flags)
    );

    pgc_fsm i_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(sync_flags),
        .state(state)
    );

    assign host_ok   = (state == ST_NORMAL);
    assign batt_sel  = (state == ST_BATTERY);
    assign pwr_state = state;

    pgc_strobe i_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .access  (host_ok),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .dq_oe   (dq_oe),
        .array_we(array_we)
    );
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       we_n,
    input logic       oe_n,
    input logic       host_ok,
    input logic       dq_oe,
    input logic       array_we,
    input logic       batt_sel,
    input logic [1:0] pwr_state
);
    AST_QUIET_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ok |-> (!dq_oe && !array_we)); // R4
    AST_WRITE_MUTES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        array_we |-> !dq_oe); // R9
    AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ce_n && !oe_n && we_n)); // R7
    AST_WRITE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        array_we |-> (!ce_n && !we_n)); // R8
    AST_NO_BATT_TO_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'b10) |=> (pwr_state != 2'b00)); // R6
    AST_BATT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        batt_sel |-> !host_ok); // R5
    AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ok && !ce_n && !we_n) |=> !array_we); // R10
endmodule

bind pwr_guard_ctrl pgc_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .host_ok  (host_ok),
    .dq_oe    (dq_oe),
    .array_we (array_we),
    .batt_sel (batt_sel),
    .pwr_state(pwr_state)
);

// File: tb/test_pwr_guard_ctrl.sv
module test_pwr_guard_ctrl;
    localparam int PERIOD = 10;
    localparam logic [1:0] S_NORM = 2'b00, S_PROT = 2'b01, S_BATT = 2'b10, S_RECV = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi = 1'b0, mid = 1'b0, lo = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic host_ok, dq_oe, array_we, batt_sel;
    logic [1:0] pwr_state;

    int total = 0;
    int bad = 0;

    logic [2:0] m_s1, m_s2;
    logic [1:0] m_st;
    logic       m_blk;

    always #(PERIOD/2) clk = ~clk;

    pwr_guard_ctrl i_pwr_guard_ctrl (
        .clk(clk), .rst_n(rst_n),
        .sup_hi_raw(hi), .sup_mid_raw(mid), .sup_lo_raw(lo),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .host_ok(host_ok), .dq_oe(dq_oe), .array_we(array_we),
        .batt_sel(batt_sel), .pwr_state(pwr_state)
    );

    function automatic logic [1:0] next_st(logic [1:0] st, logic [2:0] f);
        logic full;
        full = f[2] && f[1];
        if (!f[0]) return S_BATT;
        case (st)
            S_NORM:  return full ? S_NORM : S_PROT;
            S_BATT:  return S_RECV;
            default: return full ? S_NORM : st;
        endcase
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic acc, wr;
        acc = (m_st == S_NORM);
        wr  = !ce_n && !we_n;
        check("R3 R4 R5 R6 state", pwr_state, m_st);
        check("R3 host_ok", {1'b0, host_ok}, {1'b0, acc});
        check("R5 batt_sel", {1'b0, batt_sel}, {1'b0, m_st == S_BATT});
        check("R7 R9 dq_oe", {1'b0, dq_oe}, {1'b0, acc && !ce_n && !oe_n && we_n});
        check("R8 R10 array_we", {1'b0, array_we}, {1'b0, acc && wr && !m_blk});
    endtask

    // drive at negedge, check, clock, update model, return at next negedge
    task automatic step(logic h, logic m, logic l, logic c, logic w, logic o);
        hi = h; mid = m; lo = l; ce_n = c; we_n = w; oe_n = o;
        #1;
        check_all();
        @(posedge clk);
        m_blk = (!ce_n && !we_n) && (m_blk || m_st != S_NORM);
        m_st  = next_st(m_st, m_s2);
        m_s2  = m_s1;
        m_s1  = {hi, mid, lo};
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lvl;
        void'($urandom(32'd1234));
        m_s1 = '0; m_s2 = '0; m_st = S_BATT; m_blk = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state, strobes asserted but ignored
        ce_n = 0; we_n = 1; oe_n = 0; hi = 1; mid = 1; lo = 1;
        #1;
        check("R1 state", pwr_state, S_BATT);
        check("R1 batt_sel", {1'b0, batt_sel}, 2'd1);
        check("R1 dq_oe", {1'b0, dq_oe}, 2'd0);
        check("R1 host_ok", {1'b0, host_ok}, 2'd0);
        @(negedge clk);
        rst_n = 1;
        // R2: latency of three edges
        step(1, 1, 1, 1, 1, 1);
        step(1, 1, 1, 1, 1, 1);
        check("R2 still battery", pwr_state, S_BATT);
        step(1, 1, 1, 1, 1, 1);
        check("R6 recover", pwr_state, S_RECV);
        step(1, 1, 1, 1, 1, 1);
        check("R3 normal", pwr_state, S_NORM);
        // R7 read, R9 write over read
        step(1, 1, 1, 0, 1, 0);
        step(1, 1, 1, 0, 0, 0);
        // R10: supply dips during held write
        for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, 1);
        check("R4 protect", pwr_state, S_PROT);
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, 0, 1);
        check("R10 back normal", pwr_state, S_NORM);
        check("R10 held write blocked", {1'b0, array_we}, 2'd0);
        step(1, 1, 1, 0, 1, 1);
        step(1, 1, 1, 0, 0, 1);
        ce_n = 0; we_n = 0; #1;
        check("R10 fresh write", {1'b0, array_we}, 2'd1);
        @(negedge clk);
        // R5: direct drop to battery from normal
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 1);
        check("R5 battery", pwr_state, S_BATT);
        // R6: recover then drop back
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, 1);
        check("R6 recover blocked", pwr_state, S_RECV);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, 1);
        check("R6 back to battery", pwr_state, S_BATT);
        // random supply ramps and strobes
        lvl = 0;
        for (int n = 0; n < 4000; n++) begin
            logic [2:0] f;
            if ($urandom_range(7) == 0) begin
                if ($urandom_range(1) == 0 && lvl < 3) lvl++;
                else if (lvl > 0) lvl--;
            end
            f = {lvl >= 3, lvl >= 2, lvl >= 1};
            if ($urandom_range(31) == 0) f = 3'($urandom_range(7));
            step(f[2], f[1], f[0], 1'($urandom_range(1)),
                 1'($urandom_range(1)), 1'($urandom_range(1)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule